// File: doc/BRIEF.md
# Five-Lane 7:1 Pixel Serializer

This block takes a 35-bit pixel word once per pixel clock and sends it out on five serial data lanes, with a sixth lane that carries a framing clock. The word holds 30 bits of colour data and 5 bits of sync, data-enable and general control. The block splits the word into five 7-bit groups. During each pixel period it shifts every group out over seven bit slots, clocked by a bit clock at seven times the pixel rate. The bit clock is phase-aligned to the pixel clock and comes from outside the block.

The capture edge is picked at run time. `edge_rise_i` high samples the word on the rising edge of the pixel clock; low samples it on the falling edge. A captured word waits in a holding register. It moves into the lane shift registers only at the bit-clock edge that opens slot 0, so a frame never mixes two words. The framing lane sends a fixed high-high-low-low-low-high-high pattern in the same slots. A receiver uses that pattern to find word boundaries. When the active-low power-down input is low, every lane is floated: its enable is low and its data output is held at 0.

Top module: `pix_serializer_7x`

## Requirements
- R1: Bit `7*l+b` of `data_i` is bit b of lane l, and lane l leaves on `lane_o[l]` (l = 0..4, b = 0..6).
- R2: A frame is seven bit-clock cycles long. The first bit-clock rising edge after `rst_ni` rises opens a frame, and every seventh edge after that opens the next one.
- R3: Within a frame, each data lane sends its bits in slot order 1, 0, 6, 5, 4, 3, 2.
- R4: `clk_lane_o` carries 1,1,0,0,0,1,1 in slots 0..6 of every enabled frame.
- R5: While `rst_ni` is low, all six bits of `lane_oe_o` are 0, all `lane_o` bits are 0 and `clk_lane_o` is 0, with no clock needed.
- R6: After power-down ends, `lane_oe_o` stays 0 until the first frame that carries a captured word. It then reads all ones until the next power-down. Bit 5 belongs to the clock lane and bits 0..4 to the data lanes.
- R7: With `edge_rise_i` high, the word present at a pixel-clock rising edge is sent in the frame that opens at the next rising edge.
- R8: With `edge_rise_i` low, the word present at a pixel-clock falling edge is sent in the frame that opens at the following rising edge.
- R9: A change on `data_i` in the middle of a frame does not alter the bits of that frame.
- R10: `edge_rise_i` may change while the block runs. The frame after the change carries the word captured by the newly selected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Pixel clock |
| bclk_i | input | 1 | Bit clock, 7x pixel clock, phase-aligned |
| rst_ni | input | 1 | Active-low power-down and asynchronous reset |
| edge_rise_i | input | 1 | Capture edge: 1 rising, 0 falling |
| data_i | input | 35 | Parallel pixel word, five groups of 7 bits |
| lane_o | output | 5 | Serial data lanes |
| clk_lane_o | output | 1 | Serial framing-clock lane |
| lane_oe_o | output | 6 | Per-lane drive enable, 0 models high impedance; bit 5 is the clock lane |

## Verification
The bench goes after five corner cases:
- Slot order. A design that shifted bits in plain 6..0 order would show up on every random word.
- Word boundaries. Data changes in the middle of each frame, so a design that fed the shift registers straight from the input would send torn frames.
- Capture edge in each mode, and while the mode changes at run time. A design that ignored the edge select would send each word one half-period off, which is a full frame early or late.
- Return from power-down. A design that enabled its outputs before a word had been captured would drive a stale or zero frame.
- The framing pattern. A design whose slot counter was off by one would break that pattern in the very first enabled frame.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  // input bit index sent in slot k of a w-bit frame: 1, 0, then w-1 down to 2
  function automatic int slot_bit(input int k, input int w);
    return (k < 2) ? (1 - k) : (w + 1 - k);
  endfunction

  // framing lane level in slot k: high for the first two and last two slots
  function automatic logic clk_pat(input int k, input int w);
    return (k < 2) || (k >= w - 2);
  endfunction
endpackage

// File: rtl/pixser_capture.sv
module pixser_capture #(
  parameter int DW = 35
) (
  input  logic          pclk_i,
  input  logic          rst_ni,
  input  logic          edge_rise_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] word_o,
  output logic          seen_o
);
  logic [DW-1:0] rise_q, fall_q;
  logic          rise_seen_q, fall_seen_q;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q      <= '0;
      rise_seen_q <= 1'b0;
    end else begin
      rise_q      <= data_i;
      rise_seen_q <= 1'b1;
    end
  end

  always_ff @(negedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q      <= '0;
      fall_seen_q <= 1'b0;
    end else begin
      fall_q      <= data_i;
      fall_seen_q <= 1'b1;
    end
  end

  // select is sampled by the transfer, not by the capture
  assign word_o = edge_rise_i ? rise_q : fall_q;
  assign seen_o = edge_rise_i ? rise_seen_q : fall_seen_q;
endmodule

// File: rtl/pixser_slot_ctrl.sv
module pixser_slot_ctrl #(
  parameter int W = 7
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic seen_i,
  output logic load_o,
  output logic oe_o
);
  localparam int SW = $clog2(W);
  localparam logic [SW-1:0] LAST = SW'(W - 1);

  logic [SW-1:0] slot_q;
  logic          oe_q;

  assign load_o = (slot_q == LAST);
  assign oe_o   = oe_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= LAST;  // first edge after power-down opens slot 0
      oe_q   <= 1'b0;
    end else begin
      slot_q <= load_o ? '0 : slot_q + 1'b1;
      if (load_o && seen_i) oe_q <= 1'b1;
    end
  end

  p_frame_wrap_r2: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> (slot_q == '0));
  p_frame_step_r2: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  p_oe_hold_r6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    oe_q |=> oe_q);
endmodule

// File: rtl/pixser_lane.sv
module pixser_lane #(
  parameter int W       = 7,
  parameter bit PERMUTE = 1'b1
) (
  input  logic         bclk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  output logic         ser_o
);
  localparam int FIRST = PERMUTE ? pixser_pkg::slot_bit(0, W) : W - 1;

  logic [W-1:0] frame, sr_q;

  if (PERMUTE) begin : g_perm
    for (genvar k = 0; k < W; k++) begin : g_slot
      assign frame[W-1-k] = par_i[pixser_pkg::slot_bit(k, W)];
    end
  end else begin : g_direct
    assign frame = par_i;
  end

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= frame;
    else             sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign ser_o = sr_q[W-1];

  p_first_bit_r3: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    load_i |=> (ser_o == $past(par_i[FIRST])));
endmodule

// File: rtl/pix_serializer_7x.sv
module pix_serializer_7x #(
  parameter int N_LANES = 5,
  parameter int LANE_W  = 7
) (
  input  logic                      pclk_i,
  input  logic                      bclk_i,
  input  logic                      rst_ni,
  input  logic                      edge_rise_i,
  input  logic [N_LANES*LANE_W-1:0] data_i,
  output logic [N_LANES-1:0]        lane_o,
  output logic                      clk_lane_o,
  output logic [N_LANES:0]          lane_oe_o
);
  localparam int DW = N_LANES * LANE_W;

  logic [DW-1:0]     word;
  logic              seen, load, oe;
  logic [N_LANES:0]  ser;
  logic [LANE_W-1:0] clk_par;

  pixser_capture #(.DW(DW)) u_cap (
    .pclk_i(pclk_i), .rst_ni(rst_ni), .edge_rise_i(edge_rise_i),
    .data_i(data_i), .word_o(word), .seen_o(seen)
  );

  pixser_slot_ctrl #(.W(LANE_W)) u_ctrl (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .seen_i(seen),
    .load_o(load), .oe_o(oe)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_data
    pixser_lane #(.W(LANE_W), .PERMUTE(1'b1)) u_lane (
      .bclk_i(bclk_i), .rst_ni(rst_ni), .load_i(load),
      .par_i(word[l*LANE_W +: LANE_W]), .ser_o(ser[l])
    );
  end

  for (genvar k = 0; k < LANE_W; k++) begin : g_pat
    assign clk_par[LANE_W-1-k] = pixser_pkg::clk_pat(k, LANE_W);
  end

  pixser_lane #(.W(LANE_W), .PERMUTE(1'b0)) u_clk_lane (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .load_i(load),
    .par_i(clk_par), .ser_o(ser[N_LANES])
  );

  assign lane_o     = oe ? ser[N_LANES-1:0] : '0;
  assign clk_lane_o = oe & ser[N_LANES];
  assign lane_oe_o  = {(N_LANES+1){oe}};

  p_pd_float_r5: assert property (@(posedge bclk_i)
    !rst_ni |-> (lane_oe_o == '0 && lane_o == '0 && !clk_lane_o));
  p_clk_first_r4: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (oe && load) |=> clk_lane_o);
endmodule

// File: tb/sim_pix_serializer_7x.sv
`timescale 1ns/1ps
module sim_pix_serializer_7x;
  localparam int NL = 5;
  localparam int W  = 7;
  localparam int DW = NL * W;

  logic pclk = 1'b0, bclk = 1'b0, rst_n = 1'b0, edge_rise = 1'b1;
  logic [DW-1:0] data = '0;
  logic [NL-1:0] lane;
  logic          clk_lane;
  logic [NL:0]   oe;

  pix_serializer_7x u0 (
    .pclk_i(pclk), .bclk_i(bclk), .rst_ni(rst_n), .edge_rise_i(edge_rise),
    .data_i(data), .lane_o(lane), .clk_lane_o(clk_lane), .lane_oe_o(oe)
  );

  // 200 MHz bit clock, pixel clock rising with every seventh bit-clock edge
  initial forever #2.5 bclk = ~bclk;
  initial begin
    #2.5;
    forever begin pclk = 1'b1; #17.5; pclk = 1'b0; #17.5; end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t act=%h exp=%h", req, $time, act, exp);
    end
  endtask

  function automatic int ord(input int k);
    return (k < 2) ? (1 - k) : (W + 1 - k);
  endfunction

  // reference capture history
  logic [DW-1:0] hist_cur = '0, hist_prev = '0, fall_word = '0;
  int rise_cnt = 0, fall_cnt = 0;
  always @(posedge pclk or negedge rst_n)
    if (!rst_n) begin hist_cur <= '0; hist_prev <= '0; rise_cnt <= 0; end
    else begin hist_prev <= hist_cur; hist_cur <= data; rise_cnt <= rise_cnt + 1; end
  always @(negedge pclk or negedge rst_n)
    if (!rst_n) begin fall_word <= '0; fall_cnt <= 0; end
    else begin fall_word <= data; fall_cnt <= fall_cnt + 1; end

  int ref_slot = W - 1;
  bit ref_oe = 1'b0;
  logic [DW-1:0] frame = '0, rx = '0;
  int frames_ok = 0;

  always @(posedge bclk) begin
    #1;
    if (!rst_n) begin
      ref_slot = W - 1;
      ref_oe   = 1'b0;
      chk(oe == '0 && lane == '0 && clk_lane == 1'b0, "R5 powerdown float",
          {oe, lane, clk_lane}, '0);
    end else begin
      if (ref_slot == W - 1) begin
        frame = edge_rise ? hist_prev : fall_word;  // R7 / R8 / R10
        if (edge_rise ? (rise_cnt >= 2) : (fall_cnt >= 1)) ref_oe = 1'b1;
        ref_slot = 0;
      end else ref_slot++;
      chk(oe == {(NL+1){ref_oe}}, "R6 output enable", oe, {(NL+1){ref_oe}});
      if (ref_oe) begin
        for (int l = 0; l < NL; l++) begin
          chk(lane[l] == frame[l*W + ord(ref_slot)], "R3 slot order",
              {lane[l], 8'(ref_slot)}, {frame[l*W + ord(ref_slot)], 8'(ref_slot)});
          rx[l*W + ord(ref_slot)] = lane[l];
        end
        chk(clk_lane == ((ref_slot < 2) || (ref_slot >= W - 2)), "R4 clock pattern",
            {clk_lane, 8'(ref_slot)}, {((ref_slot < 2) || (ref_slot >= W - 2)), 8'(ref_slot)});
        if (ref_slot == W - 1) begin
          chk(rx == frame, "R1 R9 deserialized word", rx, frame);
          frames_ok++;
        end
      end else begin
        chk(lane == '0 && clk_lane == 1'b0, "R6 disabled lanes quiet", {lane, clk_lane}, '0);
      end
    end
  end

  task automatic send(input logic [DW-1:0] w);
    @(posedge pclk); #9;
    data = w;  // mid-frame change (R9)
  endtask

  task automatic leave_pd();
    @(posedge pclk); #33;  // 2 ns before the next rising edge (R2)
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge pclk);
    leave_pd();
    // R7 rising-edge capture, R1 walking ones
    for (int i = 0; i < DW; i++) send(35'(1) << i);
    send('1); send('0);
    for (int i = 0; i < 60; i++) send(35'({$urandom(), $urandom()}));
    // power-down mid-run (R5), then falling-edge mode (R8)
    @(posedge pclk); #20; rst_n = 1'b0;
    repeat (3) @(posedge pclk);
    edge_rise = 1'b0;
    leave_pd();
    for (int i = 0; i < DW; i++) send(~(35'(1) << i));
    for (int i = 0; i < 60; i++) send(35'({$urandom(), $urandom()}));
    // R10 run-time edge changes
    for (int i = 0; i < 40; i++) begin
      send(35'({$urandom(), $urandom()}));
      if (i % 7 == 3) edge_rise = ~edge_rise;
    end
    repeat (2) @(posedge pclk);
    chk(frames_ok > 200, "R2 frame count", 64'(frames_ok), 64'd200);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule